// File: doc/BRIEF.md
# Nested Four-Level Interrupt Controller

This block ranks six interrupt request sources and presents the winner to a small processor core. Each source gets one of four priority levels, which software sets with two bits per source. The controller keeps track of which levels are currently in service. A request interrupts running service only when its level is strictly above the level in service. When that service returns, the interrupted lower-level service carries on.

The six sources are:
- two active-low external pins, each with its own choice of falling-edge or low-level sensing;
- two timer overflow flags;
- a combined serial flag;
- a combined flag from a third timer.

Software reaches the enable mask and the two priority-bit registers through a byte-wide write/read port. The core takes an interrupt with an acknowledge strobe and ends it with a return strobe. On acknowledge, the block captures the vector of the winning source. It also pulses a hardware-clear line for the sources that the controller clears itself.

Top module: `intc_nest_top`

## Requirements
- R1: The enable register is at address 8'hA8 and reads back as {global, 0, source enables[5:0]}. The upper priority bits are at 8'hB7 and the lower priority bits at 8'hB8, each reading back as {2'b00, bits[5:0]}. All three registers reset to zero. Source index i uses bit i of each register, with index 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial and 5 timer2. Its level is {upper bit, lower bit}, where 0 is the lowest and 3 the highest.
- R2: With enable bit 7 clear, irq_o stays low whatever the other bits and requests are. With bit 7 set, only sources whose own enable bit is set can raise irq_o.
- R3: Among eligible requests, the one with the highest level wins, regardless of its index.
- R4: Among eligible requests at the same level, the lowest index wins.
- R5: On the cycle after an accepted acknowledge, vector_o equals 8'h03 + 8 × index (03, 0B, 13, 1B, 23, 2B). It keeps that value until the next accepted acknowledge.
- R6: irq_o is high, combinationally, exactly when an enabled request exists whose level is above the highest level in service. Any level qualifies when nothing is in service. A request at or below the level in service waits.
- R7: An accepted acknowledge marks the winner's level as in service, and cur_lvl_o becomes the highest level in service. A higher-level request therefore preempts a lower one.
- R8: A pulse on reti_i removes only the highest in-service level, so an interrupted lower level becomes current again. in_svc_o is low when no level is in service.
- R9: In falling-edge mode (ext_edge_i bit = 1), a high-to-low transition of the synchronised pin latches a request. The request holds after the pin returns high and is cleared by the acknowledge of that source.
- R10: In level mode (ext_edge_i bit = 0), the request follows the synchronised low level of the pin, with no latch. It stays asserted after acknowledge for as long as the pin is low.
- R11: clr_o[i] pulses for one cycle after an accepted acknowledge of source i, but only for timer0, timer1 and for external sources in falling-edge mode. It never pulses for the serial or timer2 sources, or for external sources in level mode.
- R12: When ack_i and reti_i are high in the same cycle, the acknowledge is ignored: no level is marked, no vector is captured and clr_o stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ext_n_i | input | 2 | External request pins, active low |
| ext_edge_i | input | 2 | Per-pin sense mode: 1 falling edge, 0 low level |
| tmr0_ovf_i | input | 1 | Timer 0 overflow flag |
| tmr1_ovf_i | input | 1 | Timer 1 overflow flag |
| ser_flag_i | input | 1 | Serial receive-or-transmit flag |
| tmr2_flag_i | input | 1 | Timer 2 overflow-or-capture flag |
| ack_i | input | 1 | Core accepts the pending interrupt |
| reti_i | input | 1 | Core returns from the current interrupt |
| irq_o | output | 1 | Eligible request present |
| vector_o | output | 8 | Vector of the last accepted interrupt |
| clr_o | output | 6 | One-cycle hardware flag-clear strobes, by source index |
| cur_lvl_o | output | 2 | Highest level in service |
| in_svc_o | output | 1 | Any level in service |

## Verification
The bench builds the block with its default parameters:
- two synchroniser stages, which fix a two-cycle pin-to-request delay in level mode and three cycles in edge mode;
- the addresses 8'hA8, 8'hB7 and 8'hB8;
- a vector base of 8'h03 with a stride of 8.

With these values the directed cases cover, at cycle level:
- a two-deep preemption and its resume;
- the same-cycle acknowledge and return;
- edge latching against level sensing.

Random register values and request patterns then exercise level ties and nesting up to level 3.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC = 6;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NUM_EXT = 2;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef enum int unsigned {
    SRC_X0  = 0,
    SRC_T0  = 1,
    SRC_X1  = 2,
    SRC_T1  = 3,
    SRC_SER = 4,
    SRC_T2  = 5
  } src_e;

  // timers always cleared by hardware on acknowledge
  localparam logic [NUM_SRC-1:0] TMR_HWCLR = (NUM_SRC'(1) << SRC_T0) | (NUM_SRC'(1) << SRC_T1);
endpackage

// File: rtl/intc_ext_req.sv
module intc_ext_req #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic edge_mode_i,
  input  logic hw_clr_i,
  output logic req_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic last_q, flag_q, pin_s, fall;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = last_q & ~pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
      last_q <= pin_s;
      if (!edge_mode_i)   flag_q <= 1'b0;
      else if (fall)      flag_q <= 1'b1;  // new edge beats clear
      else if (hw_clr_i)  flag_q <= 1'b0;
    end
  end

  assign req_o = edge_mode_i ? flag_q : ~pin_s;
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] pri_hi_i,
  input  logic [NUM_SRC-1:0] pri_lo_i,
  input  logic               svc_act_i,
  input  lvl_t               svc_lvl_i,
  output logic               win_vld_o,
  output idx_t               win_idx_o,
  output lvl_t               win_lvl_o
);
  always_comb begin
    lvl_t cand;
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    // scan downward; ">=" lets lower index take ties
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      cand = {pri_hi_i[i], pri_lo_i[i]};
      if (req_i[i] && (!svc_act_i || cand > svc_lvl_i) &&
          (!win_vld_o || cand >= win_lvl_o)) begin
        win_vld_o = 1'b1;
        win_idx_o = idx_t'(i);
        win_lvl_o = cand;
      end
    end
  end
endmodule

// File: rtl/intc_lvl_stack.sv
module intc_lvl_stack
  import intc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  lvl_t push_lvl_i,
  input  logic pop_i,
  output logic act_o,
  output lvl_t cur_lvl_o
);
  logic [NUM_LVL-1:0] map_q, top_oh;

  always_comb begin
    cur_lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (map_q[l]) cur_lvl_o = lvl_t'(l);
    end
    act_o  = |map_q;
    top_oh = act_o ? (NUM_LVL'(1) << cur_lvl_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     map_q <= '0;
    else if (pop_i)  map_q <= map_q & ~top_oh;
    else if (push_i) map_q <= map_q | (NUM_LVL'(1) << push_lvl_i);
  end
endmodule

// File: rtl/intc_nest_top.sv
module intc_nest_top
  import intc_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ADDR_EN     = 8'hA8,
  parameter logic [7:0] ADDR_PRI_HI = 8'hB7,
  parameter logic [7:0] ADDR_PRI_LO = 8'hB8,
  parameter logic [7:0] VEC_BASE    = 8'h03,
  parameter logic [7:0] VEC_STRIDE  = 8'h08
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic [NUM_EXT-1:0] ext_n_i,
  input  logic [NUM_EXT-1:0] ext_edge_i,
  input  logic               tmr0_ovf_i,
  input  logic               tmr1_ovf_i,
  input  logic               ser_flag_i,
  input  logic               tmr2_flag_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [7:0]         vector_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [LVL_W-1:0]   cur_lvl_o,
  output logic               in_svc_o
);
  localparam int PAD_W = 8 - NUM_SRC;

  logic               glb_en_q;
  logic [NUM_SRC-1:0] src_en_q, pri_hi_q, pri_lo_q;
  logic [NUM_SRC-1:0] raw_req, elig_req, clr_cap;
  logic [NUM_EXT-1:0] ext_req;
  logic               win_vld, take;
  idx_t               win_idx;
  lvl_t               win_lvl, svc_lvl;
  logic               svc_act;
  logic [7:0]         vector_q;
  logic [NUM_SRC-1:0] clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q <= 1'b0;
      src_en_q <= '0;
      pri_hi_q <= '0;
      pri_lo_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_EN) begin
        glb_en_q <= reg_wdata_i[7];
        src_en_q <= reg_wdata_i[NUM_SRC-1:0];
      end
      if (reg_addr_i == ADDR_PRI_HI) pri_hi_q <= reg_wdata_i[NUM_SRC-1:0];
      if (reg_addr_i == ADDR_PRI_LO) pri_lo_q <= reg_wdata_i[NUM_SRC-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_EN)     reg_rdata_o = {glb_en_q, {(PAD_W-1){1'b0}}, src_en_q};
    if (reg_addr_i == ADDR_PRI_HI) reg_rdata_o = {{PAD_W{1'b0}}, pri_hi_q};
    if (reg_addr_i == ADDR_PRI_LO) reg_rdata_o = {{PAD_W{1'b0}}, pri_lo_q};
  end

  assign take = ack_i & win_vld & ~reti_i;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    localparam int SRC_IDX = 2 * g;  // externals sit at even indices
    intc_ext_req #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_ni     (ext_n_i[g]),
      .edge_mode_i(ext_edge_i[g]),
      .hw_clr_i   (take && (win_idx == idx_t'(SRC_IDX))),
      .req_o      (ext_req[g])
    );
  end

  assign raw_req  = {tmr2_flag_i, ser_flag_i, tmr1_ovf_i, ext_req[1], tmr0_ovf_i, ext_req[0]};
  assign elig_req = raw_req & src_en_q & {NUM_SRC{glb_en_q}};
  assign clr_cap  = TMR_HWCLR | (NUM_SRC'(ext_edge_i[0]) << SRC_X0) | (NUM_SRC'(ext_edge_i[1]) << SRC_X1);

  intc_arb u_arb (
    .req_i    (elig_req),
    .pri_hi_i (pri_hi_q),
    .pri_lo_i (pri_lo_q),
    .svc_act_i(svc_act),
    .svc_lvl_i(svc_lvl),
    .win_vld_o(win_vld),
    .win_idx_o(win_idx),
    .win_lvl_o(win_lvl)
  );

  intc_lvl_stack u_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (take),
    .push_lvl_i(win_lvl),
    .pop_i     (reti_i),
    .act_o     (svc_act),
    .cur_lvl_o (svc_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vector_q <= '0;
      clr_q    <= '0;
    end else begin
      clr_q <= take ? ((NUM_SRC'(1) << win_idx) & clr_cap) : '0;
      if (take) vector_q <= VEC_BASE + VEC_STRIDE * 8'(win_idx);
    end
  end

  assign irq_o     = win_vld;
  assign vector_o  = vector_q;
  assign clr_o     = clr_q;
  assign cur_lvl_o = svc_lvl;
  assign in_svc_o  = svc_act;
endmodule

// File: rtl/intc_nest_chk.sv
module intc_nest_chk
  import intc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               reti_i,
  input logic               irq_o,
  input logic [7:0]         vector_o,
  input logic [NUM_SRC-1:0] clr_o,
  input logic [LVL_W-1:0]   cur_lvl_o,
  input logic               in_svc_o,
  input logic               glb_en_q
);
  logic acc;
  assign acc = ack_i & irq_o & ~reti_i;

  AST_GLB_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_q |-> !irq_o);  // R2
  AST_ACK_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> in_svc_o);  // R7
  AST_VEC_FMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (vector_o[2:0] == 3'd3) && (vector_o < 8'h30));  // R5
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(vector_o));  // R5
  AST_NEST_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_svc_o) |=> (cur_lvl_o > $past(cur_lvl_o)));  // R7
  AST_RETI_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && in_svc_o) |=> (!in_svc_o || cur_lvl_o < $past(cur_lvl_o)));  // R8
  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));  // R11
  AST_CLR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_o) |-> $past(acc));  // R11
  AST_SAME_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && reti_i) |=> (clr_o == '0));  // R12
endmodule

bind intc_nest_top intc_nest_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack_i),
  .reti_i   (reti_i),
  .irq_o    (irq_o),
  .vector_o (vector_o),
  .clr_o    (clr_o),
  .cur_lvl_o(cur_lvl_o),
  .in_svc_o (in_svc_o),
  .glb_en_q (glb_en_q)
);

// File: tb/intc_nest_top_tb_top.sv
`timescale 1ns/100ps
module intc_nest_top_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = '0, reg_wdata_i = '0, reg_rdata_o;
  logic [1:0] ext_n_i = 2'b11, ext_edge_i = 2'b00;
  logic tmr0_ovf_i = 0, tmr1_ovf_i = 0, ser_flag_i = 0, tmr2_flag_i = 0;
  logic ack_i = 0, reti_i = 0;
  logic irq_o, in_svc_o;
  logic [7:0] vector_o;
  logic [5:0] clr_o;
  logic [1:0] cur_lvl_o;

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] m_en;
  logic [5:0] m_hi, m_lo, m_req;
  logic [3:0] m_isv;

  always #2.5 clk_i = ~clk_i;

  intc_nest_top dut_i (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp<=100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic ack();
    ack_i = 1; tick(); ack_i = 0;
  endtask

  task automatic reti();
    reti_i = 1; tick(); reti_i = 0;
  endtask

  function automatic int lvl_of(int i);
    return {m_hi[i], m_lo[i]};
  endfunction

  function automatic int top_lvl();
    int t = -1;
    for (int l = 0; l < 4; l++) if (m_isv[l]) t = l;
    return t;
  endfunction

  function automatic int exp_win();
    int best = -1, bl = -1;
    for (int i = 0; i < 6; i++)
      if (m_en[7] && m_en[i] && m_req[i] && lvl_of(i) > top_lvl() && lvl_of(i) > bl) begin
        best = i; bl = lvl_of(i);
      end
    return best;
  endfunction

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    tick(2); rst_ni = 1; tick();

    // reset state
    chk("R8 reset in_svc", in_svc_o, 0);
    chk("R6 reset irq", irq_o, 0);
    chk("R5 reset vector", vector_o, 0);
    rd(8'hA8, d); chk("R1 reset en", d, 0);
    rd(8'hB7, d); chk("R1 reset hi", d, 0);

    // R1 readback
    wr(8'hA8, 8'hFF); rd(8'hA8, d); chk("R1 en readback", d, 8'hBF);
    wr(8'hB7, 8'hFF); rd(8'hB7, d); chk("R1 hi readback", d, 8'h3F);
    wr(8'hB8, 8'hC5); rd(8'hB8, d); chk("R1 lo readback", d, 8'h05);
    wr(8'hB7, 0); wr(8'hB8, 0);

    // R2 global mask
    tmr0_ovf_i = 1; wr(8'hA8, 8'h02); chk("R2 global off", irq_o, 0);
    wr(8'hA8, 8'h82); chk("R2 global on", irq_o, 1);
    wr(8'hA8, 8'h80); chk("R2 source off", irq_o, 0);

    // R4 polling order at level 0
    tmr1_ovf_i = 1; ser_flag_i = 1; tmr2_flag_i = 1;
    wr(8'hA8, 8'hBF);
    ack();
    chk("R4 tie vector", vector_o, 8'h0B);
    chk("R11 timer0 clear", clr_o, 6'b000010);
    chk("R6 equal level waits", irq_o, 0);
    tick(); chk("R11 one cycle", clr_o, 0);
    reti(); chk("R8 empty", in_svc_o, 0);

    // R3 high level beats low index
    wr(8'hB7, 8'h20); wr(8'hB8, 8'h20);
    ack();
    chk("R3 vector", vector_o, 8'h2B);
    chk("R11 timer2 no clear", clr_o, 0);
    chk("R7 level3", cur_lvl_o, 3);
    chk("R6 lower waits", irq_o, 0);
    reti();
    chk("R11 timer2 request stays", irq_o, 1);
    tmr0_ovf_i = 0; tmr1_ovf_i = 0; ser_flag_i = 0; tmr2_flag_i = 0;

    // R7 nesting
    wr(8'hB7, 8'h08); wr(8'hB8, 8'h02); wr(8'hA8, 8'h8A);
    tmr0_ovf_i = 1; tick();
    ack(); chk("R7 first lvl", cur_lvl_o, 1);
    tmr1_ovf_i = 1; #1 chk("R7 preempt irq", irq_o, 1);
    ack(); chk("R7 preempt vector", vector_o, 8'h1B);
    chk("R7 nested lvl", cur_lvl_o, 2);
    tmr1_ovf_i = 0;
    reti(); chk("R8 resume lvl", cur_lvl_o, 1);
    chk("R8 resume active", in_svc_o, 1);
    chk("R6 equal pending", irq_o, 0);
    reti(); chk("R8 all done", in_svc_o, 0);
    chk("R6 released", irq_o, 1);

    // R12 simultaneous ack and return
    d = vector_o;
    ack_i = 1; reti_i = 1; tick(); ack_i = 0; reti_i = 0;
    chk("R12 no mark", in_svc_o, 0);
    chk("R12 no clear", clr_o, 0);
    chk("R12 vector kept", vector_o, d);
    tmr0_ovf_i = 0;
    wr(8'hB7, 0); wr(8'hB8, 0);

    // R9 edge mode
    ext_edge_i = 2'b01; wr(8'hA8, 8'h81); tick(4);
    chk("R9 idle", irq_o, 0);
    ext_n_i[0] = 0; tick(); ext_n_i[0] = 1; tick(5);
    chk("R9 latched", irq_o, 1);
    ack(); chk("R9 vector", vector_o, 8'h03);
    chk("R11 edge clear", clr_o, 6'b000001);
    reti(); tick();
    chk("R9 flag cleared", irq_o, 0);

    // R10 level mode
    ext_edge_i = 2'b00; wr(8'hA8, 8'h84);
    ext_n_i[1] = 0; tick(4);
    chk("R10 level req", irq_o, 1);
    ack(); chk("R10 vector", vector_o, 8'h13);
    chk("R11 level no clear", clr_o, 0);
    reti(); chk("R10 still low", irq_o, 1);
    ext_n_i[1] = 1; tick(4);
    chk("R10 released", irq_o, 0);

    // random phase
    m_en = 8'h84; m_hi = 0; m_lo = 0; m_isv = 0;
    for (int it = 0; it < 400; it++) begin
      int w;
      if ($urandom % 4 == 0) begin
        logic [7:0] e;
        e = 8'($urandom);
        m_hi = 6'($urandom); m_lo = 6'($urandom);
        wr(8'hA8, e); wr(8'hB7, {2'b0, m_hi}); wr(8'hB8, {2'b0, m_lo});
        m_en = {e[7], 1'b0, e[5:0]};
      end
      {tmr2_flag_i, ser_flag_i, tmr1_ovf_i, tmr0_ovf_i} = 4'($urandom);
      ext_n_i = 2'($urandom);
      tick(4);
      m_req = {tmr2_flag_i, ser_flag_i, tmr1_ovf_i, ~ext_n_i[1], tmr0_ovf_i, ~ext_n_i[0]};
      w = exp_win();
      chk("R6 rand irq", irq_o, (w >= 0));
      if (w >= 0 && $urandom % 2 == 0) begin
        ack();
        chk("R4 rand vector", vector_o, 8'(3 + 8 * w));
        chk("R11 rand clear", clr_o, (w == 1 || w == 3) ? (6'd1 << w) : 6'd0);
        m_isv[lvl_of(w)] = 1'b1;
      end
      chk("R7 rand lvl", {in_svc_o, cur_lvl_o}, (m_isv != 0) ? {1'b1, 2'(top_lvl())} : 3'b0);
      if (m_isv != 0 && $urandom % 3 != 0) begin
        reti();
        m_isv[top_lvl()] = 1'b0;
        chk("R8 rand return", in_svc_o, (m_isv != 0));
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule